// File: doc/BRIEF.md
# Pivot-Row Merge Dispatcher

This block sits in front of a set of parallel sparse-row merge units during one step of Gaussian elimination. A pivot row is loaded once into a local buffer. Every non-pivot row that follows is paired with a fresh copy of that pivot row. Each pivot element of the copy is multiplied by a fixed-point factor that comes with the non-pivot row. The pair goes to one merge unit over two element channels, one for the scaled pivot and one for the non-pivot row.

Rows are handed to the merge units in rotation, one complete row per unit. Results are gathered in the same rotation, so merged rows leave in the order in which the non-pivot rows arrived. A unit that has finished early waits until its turn comes. A new pivot row for the next step is accepted only after every row started under the previous pivot has been delivered.

Top module: `merge_dispatch`

## Requirements
- R1: A loaded pivot row of 1 to PIV_DEPTH elements is replayed in full for every non-pivot row. The pivot channel of the chosen unit carries the same columns, in load order, ending with its last flag on the final element. A load that reaches PIV_DEPTH elements ends there.
- R2: Each replayed pivot value equals the product of the stored signed value and the row's signed multiplier (FRAC_W fraction bits), plus 2^(FRAC_W-1), arithmetically shifted right by FRAC_W, and keeping the low VAL_W bits.
- R3: The multiplier is sampled with the first accepted element of a non-pivot row. The np_mult value on later elements of the same row has no effect.
- R4: Counting from reset, non-pivot row j goes to unit j mod N_UNITS, with both of its channels on that unit. The dispatcher moves to the next unit only after the last element of both the non-pivot row and the pivot replay has been accepted.
- R5: Merged rows leave the output in the order in which their non-pivot rows arrived, whichever unit finishes first. out_last marks the final element of each row.
- R6: When the unit whose turn it is has no data, out_valid stays low, even if other units hold finished rows.
- R7: piv_ready is high only when no row is in dispatch or awaiting delivery. A pivot element offered in the same cycle as a non-pivot element wins, and np_ready is low. np_ready stays low from reset until a complete pivot row has been loaded, and stays low while a new one is being loaded.
- R8: During reset out_valid is low, no unit channel is valid, piv_ready is high and np_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| piv_valid | input | 1 | Pivot load element valid |
| piv_ready | output | 1 | Pivot load element accepted |
| piv_col | input | COL_W | Pivot element column |
| piv_val | input | VAL_W | Pivot element value |
| piv_last | input | 1 | Final pivot element |
| np_valid | input | 1 | Non-pivot element valid |
| np_ready | output | 1 | Non-pivot element accepted |
| np_col | input | COL_W | Non-pivot element column |
| np_val | input | VAL_W | Non-pivot element value |
| np_last | input | 1 | Final element of the non-pivot row |
| np_mult | input | VAL_W | Signed fixed-point row multiplier |
| mu_p_valid | output | N_UNITS | Scaled pivot element valid, per unit |
| mu_p_ready | input | N_UNITS | Unit accepts pivot element |
| mu_p_col | output | N_UNITS x COL_W | Pivot column to units |
| mu_p_val | output | N_UNITS x VAL_W | Scaled pivot value to units |
| mu_p_last | output | N_UNITS | Final pivot element to units |
| mu_n_valid | output | N_UNITS | Non-pivot element valid, per unit |
| mu_n_ready | input | N_UNITS | Unit accepts non-pivot element |
| mu_n_col | output | N_UNITS x COL_W | Non-pivot column to units |
| mu_n_val | output | N_UNITS x VAL_W | Non-pivot value to units |
| mu_n_last | output | N_UNITS | Final non-pivot element to units |
| mu_o_valid | input | N_UNITS | Unit result element valid |
| mu_o_ready | output | N_UNITS | Result element taken from unit |
| mu_o_col | input | N_UNITS x COL_W | Result column from units |
| mu_o_val | input | N_UNITS x VAL_W | Result value from units |
| mu_o_last | input | N_UNITS | Final result element from units |
| out_valid | output | 1 | Merged element valid |
| out_ready | input | 1 | Consumer accepts merged element |
| out_col | output | COL_W | Merged element column |
| out_val | output | VAL_W | Merged element value |
| out_last | output | 1 | Final element of a merged row |

## Verification
The bench builds the block with three units, 16-bit values, 8 fraction bits and a 16-entry pivot buffer. The three behavioural units are given finishing delays that shrink with the unit index, so later rows are ready before earlier ones and the in-order collection and its stall are forced. Pivot lengths of 1, 5 and the full 16 entries are swept against multipliers of positive and negative unity, one half, zero, one LSB and large negative factors. Rotation is therefore seen to wrap several times across pivot reloads, and rounding is exercised at the extremes of the value range.

// File: rtl/mdisp_pkg.sv
package mdisp_pkg;
  // Width of a unit index; at least one bit even for a single unit.
  function automatic int sel_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mdisp_pivot_buf.sv
module mdisp_pivot_buf #(
  parameter int COL_W = 8,
  parameter int VAL_W = 16,
  parameter int DEPTH = 16,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [COL_W-1:0] wr_col,
  input  logic [VAL_W-1:0] wr_val,
  input  logic             wr_last,
  input  logic [IW-1:0]    rd_idx,
  output logic [COL_W-1:0] rd_col,
  output logic [VAL_W-1:0] rd_val,
  output logic [LW-1:0]    len,
  output logic             have
);
  logic [COL_W-1:0] mem_col [DEPTH];
  logic [VAL_W-1:0] mem_val [DEPTH];
  logic [IW-1:0]    wr_ptr, wr_ptr_n;
  logic [LW-1:0]    len_n;
  logic             have_n, fin;

  assign fin = wr_last || (wr_ptr == IW'(DEPTH - 1));

  always_comb begin
    wr_ptr_n = wr_ptr;
    len_n    = len;
    have_n   = have;
    if (wr_en) begin
      if (wr_ptr == '0) have_n = 1'b0;
      if (fin) begin
        wr_ptr_n = '0;
        len_n    = LW'(wr_ptr) + LW'(1);
        have_n   = 1'b1;
      end else begin
        wr_ptr_n = wr_ptr + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      len    <= '0;
      have   <= 1'b0;
    end else begin
      wr_ptr <= wr_ptr_n;
      len    <= len_n;
      have   <= have_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_col[wr_ptr] <= wr_col;
      mem_val[wr_ptr] <= wr_val;
    end
  end

  assign rd_col = mem_col[rd_idx];
  assign rd_val = mem_val[rd_idx];
endmodule

// File: rtl/mdisp_scale.sv
module mdisp_scale #(
  parameter int COL_W  = 8,
  parameter int VAL_W  = 16,
  parameter int FRAC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [COL_W-1:0] in_col,
  input  logic [VAL_W-1:0] in_val,
  input  logic             in_last,
  input  logic [VAL_W-1:0] mult,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [COL_W-1:0] out_col,
  output logic [VAL_W-1:0] out_val,
  output logic             out_last
);
  localparam int PW = 2 * VAL_W;
  localparam logic signed [PW-1:0] HALF = PW'(1) << (FRAC_W - 1);

  logic signed [PW-1:0] prod, rnd;
  logic [VAL_W-1:0]     scaled;
  logic                 load, valid_n;
  logic                 rnd_unused;

  assign prod   = $signed(in_val) * $signed(mult);
  assign rnd    = prod + HALF;
  assign scaled = rnd[FRAC_W +: VAL_W];
  assign rnd_unused = ^{rnd[FRAC_W-1:0], rnd[PW-1:FRAC_W+VAL_W]};

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_comb begin
    valid_n = out_valid;
    if (load) valid_n = 1'b1;
    else if (out_ready) valid_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_n;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      out_col  <= in_col;
      out_val  <= scaled;
      out_last <= in_last;
    end
  end
endmodule

// File: rtl/mdisp_collect.sv
module mdisp_collect import mdisp_pkg::*; #(
  parameter int N_UNITS = 3,
  parameter int COL_W   = 8,
  parameter int VAL_W   = 16,
  localparam int SEL_W  = sel_bits(N_UNITS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [N_UNITS-1:0]              u_valid,
  output logic [N_UNITS-1:0]              u_ready,
  input  logic [N_UNITS-1:0][COL_W-1:0]   u_col,
  input  logic [N_UNITS-1:0][VAL_W-1:0]   u_val,
  input  logic [N_UNITS-1:0]              u_last,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic [COL_W-1:0]                out_col,
  output logic [VAL_W-1:0]                out_val,
  output logic                            out_last,
  output logic                            row_done
);
  logic [SEL_W-1:0] sel, sel_n;

  assign out_valid = u_valid[sel];
  assign out_col   = u_col[sel];
  assign out_val   = u_val[sel];
  assign out_last  = u_last[sel];
  assign row_done  = out_valid && out_ready && out_last;

  for (genvar k = 0; k < N_UNITS; k++) begin : g_rdy
    assign u_ready[k] = out_ready && (sel == SEL_W'(k));
  end

  always_comb begin
    sel_n = sel;
    if (row_done) sel_n = (sel == SEL_W'(N_UNITS - 1)) ? '0 : sel + SEL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel <= '0;
    else        sel <= sel_n;
  end
endmodule

// File: rtl/merge_dispatch.sv
module merge_dispatch import mdisp_pkg::*; #(
  parameter int N_UNITS   = 3,
  parameter int VAL_W     = 16,
  parameter int COL_W     = 8,
  parameter int FRAC_W    = 8,
  parameter int PIV_DEPTH = 16,
  parameter int OUT_W     = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            piv_valid,
  output logic                            piv_ready,
  input  logic [COL_W-1:0]                piv_col,
  input  logic [VAL_W-1:0]                piv_val,
  input  logic                            piv_last,
  input  logic                            np_valid,
  output logic                            np_ready,
  input  logic [COL_W-1:0]                np_col,
  input  logic [VAL_W-1:0]                np_val,
  input  logic                            np_last,
  input  logic [VAL_W-1:0]                np_mult,
  output logic [N_UNITS-1:0]              mu_p_valid,
  input  logic [N_UNITS-1:0]              mu_p_ready,
  output logic [N_UNITS-1:0][COL_W-1:0]   mu_p_col,
  output logic [N_UNITS-1:0][VAL_W-1:0]   mu_p_val,
  output logic [N_UNITS-1:0]              mu_p_last,
  output logic [N_UNITS-1:0]              mu_n_valid,
  input  logic [N_UNITS-1:0]              mu_n_ready,
  output logic [N_UNITS-1:0][COL_W-1:0]   mu_n_col,
  output logic [N_UNITS-1:0][VAL_W-1:0]   mu_n_val,
  output logic [N_UNITS-1:0]              mu_n_last,
  input  logic [N_UNITS-1:0]              mu_o_valid,
  output logic [N_UNITS-1:0]              mu_o_ready,
  input  logic [N_UNITS-1:0][COL_W-1:0]   mu_o_col,
  input  logic [N_UNITS-1:0][VAL_W-1:0]   mu_o_val,
  input  logic [N_UNITS-1:0]              mu_o_last,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic [COL_W-1:0]                out_col,
  output logic [VAL_W-1:0]                out_val,
  output logic                            out_last
);
  localparam int SEL_W = sel_bits(N_UNITS);
  localparam int IW    = (PIV_DEPTH > 1) ? $clog2(PIV_DEPTH) : 1;
  localparam int LW    = $clog2(PIV_DEPTH + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i = rst_q[1];

  logic [SEL_W-1:0] in_sel, in_sel_n;
  logic             row_active, row_active_n;
  logic             np_done, np_done_n, piv_issued, piv_issued_n, piv_done, piv_done_n;
  logic [LW-1:0]    rd_ptr, rd_ptr_n;
  logic [VAL_W-1:0] mult_q, mult_n;
  logic [OUT_W-1:0] outstanding, outstanding_n;

  logic [COL_W-1:0] b_col;
  logic [VAL_W-1:0] b_val;
  logic [LW-1:0]    b_len;
  logic             b_have;
  logic             piv_take, np_gate, np_hs, row_start, row_end;
  logic             s_in_valid, s_in_ready, s_issue, issue_last;
  logic             s_valid, s_last, p_take, row_out_done;
  logic [COL_W-1:0] s_col;
  logic [VAL_W-1:0] s_val;

  assign piv_ready = (outstanding == '0) && !row_active && !s_valid;
  assign piv_take  = piv_valid && piv_ready;

  mdisp_pivot_buf #(.COL_W(COL_W), .VAL_W(VAL_W), .DEPTH(PIV_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_i), .wr_en(piv_take), .wr_col(piv_col), .wr_val(piv_val),
    .wr_last(piv_last), .rd_idx(rd_ptr[IW-1:0]), .rd_col(b_col), .rd_val(b_val),
    .len(b_len), .have(b_have)
  );

  // non-pivot row forwarding to the unit whose turn it is
  assign np_gate   = b_have && !piv_take && !np_done && (row_active || (outstanding != '1));
  assign np_ready  = np_gate && mu_n_ready[in_sel];
  assign np_hs     = np_valid && np_ready;
  assign row_start = np_hs && !row_active;

  // pivot replay through the scaling register
  assign s_in_valid = row_active && !piv_issued;
  assign s_issue    = s_in_valid && s_in_ready;
  assign issue_last = (rd_ptr == b_len - LW'(1));

  mdisp_scale #(.COL_W(COL_W), .VAL_W(VAL_W), .FRAC_W(FRAC_W)) u_scale (
    .clk(clk), .rst_n(rst_i), .in_valid(s_in_valid), .in_ready(s_in_ready),
    .in_col(b_col), .in_val(b_val), .in_last(issue_last), .mult(mult_q),
    .out_valid(s_valid), .out_ready(mu_p_ready[in_sel]), .out_col(s_col),
    .out_val(s_val), .out_last(s_last)
  );

  assign p_take  = s_valid && mu_p_ready[in_sel];
  assign row_end = row_active && (np_done || (np_hs && np_last)) && (piv_done || (p_take && s_last));

  for (genvar k = 0; k < N_UNITS; k++) begin : g_unit
    assign mu_n_valid[k] = (in_sel == SEL_W'(k)) && np_valid && np_gate;
    assign mu_n_col[k]   = np_col;
    assign mu_n_val[k]   = np_val;
    assign mu_n_last[k]  = np_last;
    assign mu_p_valid[k] = (in_sel == SEL_W'(k)) && s_valid;
    assign mu_p_col[k]   = s_col;
    assign mu_p_val[k]   = s_val;
    assign mu_p_last[k]  = s_last;
  end

  mdisp_collect #(.N_UNITS(N_UNITS), .COL_W(COL_W), .VAL_W(VAL_W)) u_coll (
    .clk(clk), .rst_n(rst_i), .u_valid(mu_o_valid), .u_ready(mu_o_ready),
    .u_col(mu_o_col), .u_val(mu_o_val), .u_last(mu_o_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_col(out_col), .out_val(out_val), .out_last(out_last),
    .row_done(row_out_done)
  );

  always_comb begin
    in_sel_n      = in_sel;
    row_active_n  = row_active || row_start;
    np_done_n     = np_done || (np_hs && np_last);
    piv_done_n    = piv_done || (p_take && s_last);
    piv_issued_n  = piv_issued || (s_issue && issue_last);
    rd_ptr_n      = s_issue ? rd_ptr + LW'(1) : rd_ptr;
    mult_n        = row_start ? np_mult : mult_q;
    outstanding_n = outstanding + OUT_W'(row_start) - OUT_W'(row_out_done);
    if (row_end) begin
      in_sel_n     = (in_sel == SEL_W'(N_UNITS - 1)) ? '0 : in_sel + SEL_W'(1);
      row_active_n = 1'b0;
      np_done_n    = 1'b0;
      piv_done_n   = 1'b0;
      piv_issued_n = 1'b0;
      rd_ptr_n     = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      in_sel      <= '0;
      row_active  <= 1'b0;
      np_done     <= 1'b0;
      piv_done    <= 1'b0;
      piv_issued  <= 1'b0;
      rd_ptr      <= '0;
      mult_q      <= '0;
      outstanding <= '0;
    end else begin
      in_sel      <= in_sel_n;
      row_active  <= row_active_n;
      np_done     <= np_done_n;
      piv_done    <= piv_done_n;
      piv_issued  <= piv_issued_n;
      rd_ptr      <= rd_ptr_n;
      mult_q      <= mult_n;
      outstanding <= outstanding_n;
    end
  end
endmodule

// File: rtl/merge_dispatch_chk.sv
module merge_dispatch_chk #(
  parameter int N_UNITS = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               piv_valid,
  input logic               piv_ready,
  input logic               np_valid,
  input logic               np_ready,
  input logic [N_UNITS-1:0] mu_n_valid,
  input logic [N_UNITS-1:0] mu_n_ready,
  input logic [N_UNITS-1:0] mu_p_valid,
  input logic [N_UNITS-1:0] mu_o_valid,
  input logic               out_valid
);
  p_one_unit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mu_n_valid) && $onehot0(mu_p_valid));

  p_same_unit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|mu_n_valid) && (|mu_p_valid)) |-> (mu_n_valid == mu_p_valid));

  p_np_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (np_valid && np_ready) |-> (($countones(mu_n_valid) == 1) && ((mu_n_valid & mu_n_ready) != '0)));

  p_quiet_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    piv_ready |-> (mu_p_valid == '0));

  p_load_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (piv_valid && piv_ready) |-> !np_ready);

  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mu_o_valid == '0) |-> !out_valid);
endmodule

bind merge_dispatch merge_dispatch_chk #(.N_UNITS(N_UNITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .piv_valid(piv_valid), .piv_ready(piv_ready),
  .np_valid(np_valid), .np_ready(np_ready), .mu_n_valid(mu_n_valid),
  .mu_n_ready(mu_n_ready), .mu_p_valid(mu_p_valid), .mu_o_valid(mu_o_valid),
  .out_valid(out_valid)
);

// File: tb/merge_dispatch_test.sv
module merge_unit_model #(
  parameter int CW  = 8,
  parameter int VW  = 16,
  parameter int DLY = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          p_valid,
  output logic          p_ready,
  input  logic [CW-1:0] p_col,
  input  logic [VW-1:0] p_val,
  input  logic          p_last,
  input  logic          n_valid,
  output logic          n_ready,
  input  logic [CW-1:0] n_col,
  input  logic [VW-1:0] n_val,
  input  logic          n_last,
  output logic          o_valid,
  input  logic          o_ready,
  output logic [CW-1:0] o_col,
  output logic [VW-1:0] o_val,
  output logic          o_last
);
  logic [CW-1:0] nc [64];
  logic [CW-1:0] pc [64];
  logic [VW-1:0] nv [64];
  logic [VW-1:0] pv [64];
  int ncnt, pcnt, tmr, e, phase;
  logic nd, pd;
  logic p_hs, n_hs;

  assign p_ready = (phase == 0) && !pd;
  assign n_ready = (phase == 0) && !nd;
  assign p_hs    = p_valid && p_ready;
  assign n_hs    = n_valid && n_ready;
  assign o_valid = (phase == 2);
  assign o_col   = (e < ncnt) ? nc[e[5:0]] : pc[6'(e - ncnt)];
  assign o_val   = (e < ncnt) ? nv[e[5:0]] : pv[6'(e - ncnt)];
  assign o_last  = (e == ncnt + pcnt - 1);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 0; ncnt <= 0; pcnt <= 0; nd <= 1'b0; pd <= 1'b0; e <= 0; tmr <= 0;
    end else begin
      case (phase)
        0: begin
          if (p_hs) begin
            pc[pcnt[5:0]] <= p_col; pv[pcnt[5:0]] <= p_val; pcnt <= pcnt + 1;
            if (p_last) pd <= 1'b1;
          end
          if (n_hs) begin
            nc[ncnt[5:0]] <= n_col; nv[ncnt[5:0]] <= n_val; ncnt <= ncnt + 1;
            if (n_last) nd <= 1'b1;
          end
          if ((pd || (p_hs && p_last)) && (nd || (n_hs && n_last))) begin
            phase <= 1; tmr <= DLY;
          end
        end
        1: begin
          if (tmr == 0) begin phase <= 2; e <= 0; end
          else tmr <= tmr - 1;
        end
        default: begin
          if (o_valid && o_ready) begin
            if (o_last) begin
              phase <= 0; ncnt <= 0; pcnt <= 0; nd <= 1'b0; pd <= 1'b0;
            end else e <= e + 1;
          end
        end
      endcase
    end
  end
endmodule

module merge_dispatch_test;
  localparam int N = 3, VW = 16, CW = 8, FW = 8, PD = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic piv_valid, piv_ready, piv_last;
  logic [CW-1:0] piv_col;
  logic [VW-1:0] piv_val;
  logic np_valid, np_ready, np_last;
  logic [CW-1:0] np_col;
  logic [VW-1:0] np_val, np_mult;
  logic [N-1:0] mu_p_valid, mu_p_ready, mu_p_last, mu_n_valid, mu_n_ready, mu_n_last;
  logic [N-1:0] mu_o_valid, mu_o_ready, mu_o_last;
  logic [N-1:0][CW-1:0] mu_p_col, mu_n_col, mu_o_col;
  logic [N-1:0][VW-1:0] mu_p_val, mu_n_val, mu_o_val;
  logic out_valid, out_ready, out_last;
  logic [CW-1:0] out_col;
  logic [VW-1:0] out_val;

  merge_dispatch #(.N_UNITS(N), .VAL_W(VW), .COL_W(CW), .FRAC_W(FW), .PIV_DEPTH(PD)) uut (
    .clk(clk), .rst_n(rst_n),
    .piv_valid(piv_valid), .piv_ready(piv_ready), .piv_col(piv_col), .piv_val(piv_val), .piv_last(piv_last),
    .np_valid(np_valid), .np_ready(np_ready), .np_col(np_col), .np_val(np_val), .np_last(np_last), .np_mult(np_mult),
    .mu_p_valid(mu_p_valid), .mu_p_ready(mu_p_ready), .mu_p_col(mu_p_col), .mu_p_val(mu_p_val), .mu_p_last(mu_p_last),
    .mu_n_valid(mu_n_valid), .mu_n_ready(mu_n_ready), .mu_n_col(mu_n_col), .mu_n_val(mu_n_val), .mu_n_last(mu_n_last),
    .mu_o_valid(mu_o_valid), .mu_o_ready(mu_o_ready), .mu_o_col(mu_o_col), .mu_o_val(mu_o_val), .mu_o_last(mu_o_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_col(out_col), .out_val(out_val), .out_last(out_last)
  );

  for (genvar k = 0; k < N; k++) begin : g_mu
    merge_unit_model #(.CW(CW), .VW(VW), .DLY((N - k) * 9)) m (
      .clk(clk), .rst_n(rst_n),
      .p_valid(mu_p_valid[k]), .p_ready(mu_p_ready[k]), .p_col(mu_p_col[k]), .p_val(mu_p_val[k]), .p_last(mu_p_last[k]),
      .n_valid(mu_n_valid[k]), .n_ready(mu_n_ready[k]), .n_col(mu_n_col[k]), .n_val(mu_n_val[k]), .n_last(mu_n_last[k]),
      .o_valid(mu_o_valid[k]), .o_ready(mu_o_ready[k]), .o_col(mu_o_col[k]), .o_val(mu_o_val[k]), .o_last(mu_o_last[k])
    );
  end

  int n_tests = 0, n_fail = 0;
  int pv_col [PD];
  int pv_val [PD];
  int cur_plen = 0, row_no = 0;
  logic [CW-1:0] exp_col [1024];
  logic [VW-1:0] exp_val [1024];
  logic          exp_last [1024];
  int exp_wr = 0, exp_rd = 0, stall_seen = 0, cyc = 0;
  bit running = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [VW-1:0] scl(input int v, input int m);
    longint p;
    p = longint'(v) * longint'(m) + longint'(1 << (FW - 1));
    p = p >>> FW;
    return p[VW-1:0];
  endfunction

  task automatic push(input int c, input logic [VW-1:0] v, input logic l);
    exp_col[exp_wr] = CW'(c); exp_val[exp_wr] = v; exp_last[exp_wr] = l; exp_wr++;
  endtask

  task automatic load_pivot(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      piv_valid = 1'b1; piv_col = CW'(pv_col[i]); piv_val = VW'(pv_val[i]); piv_last = (i == len - 1);
      forever begin #1; if (piv_ready) break; @(negedge clk); end
      @(posedge clk);
    end
    @(negedge clk);
    piv_valid = 1'b0; piv_last = 1'b0;
    cur_plen = len;
  endtask

  task automatic send_row(input int len, input int mult);
    int rid;
    rid = row_no;
    for (int i = 0; i < len; i++) push((rid * 5 + i * 3) % 256, VW'(rid * 97 - i * 211 + 13), 1'b0);
    for (int j = 0; j < cur_plen; j++) push(pv_col[j], scl(pv_val[j], mult), (j == cur_plen - 1));
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      np_valid = 1'b1; np_col = CW'((rid * 5 + i * 3) % 256); np_val = VW'(rid * 97 - i * 211 + 13);
      np_last  = (i == len - 1);
      np_mult  = (i == 0) ? VW'(mult) : VW'(mult ^ 16'h5a5a);  // R3: later values must be ignored
      forever begin #1; if (np_ready) break; @(negedge clk); end
      if (i == 0) chk(mu_n_valid == N'(1 << (rid % N)), "R4", "row unit select", int'(mu_n_valid), 1 << (rid % N));
      @(posedge clk);
    end
    @(negedge clk);
    np_valid = 1'b0; np_last = 1'b0;
    row_no++;
  endtask

  task automatic drain();
    while (exp_rd != exp_wr) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // output sink with periodic back-pressure; compares every accepted element
  initial begin
    out_ready = 1'b0;
    wait (running);
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = ((cyc % 5) != 2);
      #1;
      if (!out_valid && (mu_o_valid != '0)) stall_seen++;
      if (out_valid && out_ready) begin
        if (exp_rd >= exp_wr) chk(1'b0, "R5", "unexpected output element", int'(out_col), -1);
        else begin
          chk(out_col == exp_col[exp_rd], "R1", "column", int'(out_col), int'(exp_col[exp_rd]));
          chk(out_val == exp_val[exp_rd], "R2", "value", int'($signed(out_val)), int'($signed(exp_val[exp_rd])));
          chk(out_last == exp_last[exp_rd], "R5", "last flag", int'(out_last), int'(exp_last[exp_rd]));
          exp_rd++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", exp_rd, exp_wr);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    piv_valid = 1'b0; piv_col = '0; piv_val = '0; piv_last = 1'b0;
    np_valid = 1'b0; np_col = '0; np_val = '0; np_last = 1'b0; np_mult = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
    chk(piv_ready == 1'b1, "R8", "piv_ready in reset", int'(piv_ready), 1);
    chk(np_ready == 1'b0, "R8", "np_ready in reset", int'(np_ready), 0);
    chk((mu_p_valid | mu_n_valid) == '0, "R8", "unit valids in reset", int'(mu_p_valid | mu_n_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    running = 1'b1;

    // R7: no pivot loaded yet, non-pivot rows must be refused
    np_valid = 1'b1; np_last = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk(np_ready == 1'b0 && mu_n_valid == '0, "R7", "np_ready without pivot", int'(np_ready), 0);
      @(negedge clk);
    end
    np_valid = 1'b0; np_last = 1'b0;

    // pivot of five with extreme values
    pv_col[0] = 1; pv_val[0] = 1;
    pv_col[1] = 3; pv_val[1] = -1;
    pv_col[2] = 4; pv_val[2] = 255;
    pv_col[3] = 6; pv_val[3] = -32768;
    pv_col[4] = 9; pv_val[4] = 32767;
    load_pivot(5);
    send_row(3, 256);
    send_row(1, -256);
    #1;
    chk(piv_ready == 1'b0, "R7", "piv_ready with rows outstanding", int'(piv_ready), 0);
    send_row(7, 128);
    send_row(2, 1);
    send_row(5, 0);
    send_row(4, -1);
    send_row(6, 384);
    drain();
    #1;
    chk(piv_ready == 1'b1, "R7", "piv_ready after drain", int'(piv_ready), 1);

    // R7: pivot element and non-pivot element offered together
    pv_col[0] = 7; pv_val[0] = -3;
    @(negedge clk);
    piv_valid = 1'b1; piv_col = CW'(7); piv_val = VW'(-3); piv_last = 1'b1;
    np_valid = 1'b1; np_last = 1'b0;
    #1;
    chk(np_ready == 1'b0 && piv_ready == 1'b1, "R7", "load priority np_ready", int'(np_ready), 0);
    piv_valid = 1'b0; np_valid = 1'b0; piv_last = 1'b0;
    load_pivot(1);
    send_row(2, 129);
    send_row(3, -129);
    drain();

    // full-depth pivot
    for (int i = 0; i < PD; i++) begin pv_col[i] = 2 * i + 1; pv_val[i] = i * 1000 - 7000; end
    load_pivot(PD);
    send_row(4, 3);
    send_row(1, -700);
    send_row(6, 255);
    send_row(2, 64);
    send_row(3, -32768);
    drain();

    chk(stall_seen > 0, "R6", "in-order stall observed", stall_seen, 1);
    chk(exp_rd == exp_wr, "R5", "elements delivered", exp_rd, exp_wr);
    finish_run();
  end
endmodule